// File: doc/BRIEF.md
# Hashed Page Table Walker

This block looks up one virtual page in a hashed page table that lives in ordinary memory. A request supplies a primary hash, a 32-bit compare word, a protection key, a no-execute flag and an access kind. The compare word is the virtual segment ID shifted left by 7, ORed with the page index shifted right by 10. The walker reads entry groups through a single 32-bit memory port. It scans the primary group first. When the primary pass does not grant access, it scans a secondary group located by the complemented hash.

Each entry is two words. Word 0 holds the tag. Word 1 holds the real page number, the attribute bits and the page-protection field. The walker derives access rights from the protection field and the request's key. It then sets the referenced and changed flags and writes word 1 back when those flags change. It reports one of four outcomes: hit, protection violation, miss or inconsistency.

Top module: `hpt_walker`

## Requirements
- R1: A group starts at byte address `cfg_base + ((hash & cfg_mask) * 64)`. Entry i has word 0 at offset 8*i and word 1 at 8*i+4. Entries are scanned in index order 0 to 7.
- R2: Word 0 matches only when bit 31 is set, bit 6 equals the pass number (0 primary, 1 secondary), and word 0 AND 0x7FFFFFBF equals the compare word. Word 1 is read only for a matching entry.
- R3: Rights are reported on `rsp_prot` as {execute, write, read} in bits [2:0]. The protection field is word 1 bits [1:0]. With key 0, values 0, 1 and 2 give read and write, and 3 gives read only. With key 1, value 0 gives nothing, 1 and 3 give read only, and 2 gives read and write. Execute equals read unless no-execute is set. Access kinds are encoded 0 read, 1 write, 2 fetch.
- R4: A matching entry whose rights allow the access ends the scan at once. The result is a hit (`rsp_code` 0). `rsp_word` carries that entry's updated word 1 and `rsp_prot` its rights.
- R5: A matching entry that denies the access is recorded, and the scan continues. The last such entry is the one selected. Without a grant, the result is a violation (`rsp_code` 1) that carries the selected entry's updated word 1 and rights.
- R6: The secondary pass uses the complement of the hash and runs only when the primary pass gives no hit. A secondary miss (`rsp_code` 2) leaves the primary result in place. Any other secondary result replaces the primary result.
- R7: After a match has been recorded in either pass, a later match whose word 1 differs under mask 0xFFFFF07B ends that pass at once with an inconsistency (`rsp_code` 3). That pass makes no write-back.
- R8: The selected entry of a pass gets bit 8 (referenced) set, and bit 7 (changed) set only on a granted write. The word is written back to the entry's word 1 address only if a bit changes.
- R9: `rsp_valid` is a one-cycle pulse. For miss and inconsistency, `rsp_word` and `rsp_prot` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Walker idle |
| req_hash | input | HASH_W | Primary hash |
| req_cmp | input | 32 | Compare word (segment ID and abbreviated page index) |
| req_key | input | 1 | Protection key |
| req_nx | input | 1 | No-execute flag |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| cfg_base | input | AW | Table base byte address |
| cfg_mask | input | HASH_W | Hash mask selecting the group |
| mem_rd | output | 1 | Read command, one cycle |
| mem_wr | output | 1 | Write command, one cycle |
| mem_addr | output | AW | Byte address for read or write |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_code | output | 2 | 0 hit, 1 violation, 2 miss, 3 inconsistency |
| rsp_word | output | 32 | Updated word 1 of the reported entry |
| rsp_prot | output | 3 | Rights {execute, write, read} |

## Verification
The hardest outcomes to reach are the cross-pass ones. In one, the primary pass records a violation and writes back the referenced flag. The secondary pass then either finds nothing, so the violation survives, or finds a match with a different page frame, so inconsistency replaces it. The stimulus builds these cases by placing entries with the hash-select bit set in the complemented group, alongside violating entries in the primary group. It then counts the memory reads and writes the walker issues, so that skipped word-1 reads and suppressed write-backs are visible at the port.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    RES_HIT   = 2'd0,
    RES_PROT  = 2'd1,
    RES_MISS  = 2'd2,
    RES_INCON = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  localparam logic [31:0] TAG_MASK  = 32'h7FFF_FFBF;
  localparam logic [31:0] CONS_MASK = 32'hFFFF_F07B;
  localparam int VALID_BIT = 31;
  localparam int HSEL_BIT  = 6;
  localparam int REF_BIT   = 8;
  localparam int CHG_BIT   = 7;

  // Rights as {exec, write, read}
  function automatic logic [2:0] pp_rights(logic key, logic [1:0] pp, logic nx);
    logic r, w;
    if (!key) begin
      r = 1'b1;
      w = (pp != 2'd3);
    end else begin
      r = (pp != 2'd0);
      w = (pp == 2'd2);
    end
    return {r & ~nx, w, r};
  endfunction

  function automatic logic access_ok(logic [2:0] rt, acc_e a);
    case (a)
      ACC_READ:  return rt[0];
      ACC_WRITE: return rt[1];
      ACC_FETCH: return rt[2];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] merge_flags(logic [31:0] w1, logic granted, logic is_wr);
    logic [31:0] o;
    o = w1;
    o[REF_BIT] = 1'b1;
    if (granted && is_wr) o[CHG_BIT] = 1'b1;
    return o;
  endfunction

endpackage

// File: rtl/hpt_grp_addr.sv
module hpt_grp_addr #(
  parameter int AW      = 32,
  parameter int HASH_W  = 19,
  parameter int ENTRIES = 8
) (
  input  logic [AW-1:0]              base,
  input  logic [HASH_W-1:0]          mask,
  input  logic [HASH_W-1:0]          hash,
  input  logic                       pass,
  input  logic [$clog2(ENTRIES)-1:0] idx,
  input  logic                       word_sel,
  output logic [AW-1:0]              addr
);
  localparam int ENT_SHIFT = 3;
  localparam int GRP_SHIFT = $clog2(ENTRIES) + ENT_SHIFT;

  logic [HASH_W-1:0] h_sel;
  logic [HASH_W-1:0] grp;

  always_comb begin
    h_sel = pass ? ~hash : hash;
    grp   = h_sel & mask;
    addr  = base + (AW'(grp) << GRP_SHIFT) + (AW'(idx) << ENT_SHIFT)
          + (word_sel ? AW'(4) : AW'(0));
  end
endmodule

// File: rtl/hpt_pte_eval.sv
module hpt_pte_eval
  import hpt_pkg::*;
(
  input  logic [31:0] w0,
  input  logic [31:0] w1,
  input  logic [31:0] cmp,
  input  logic        pass,
  input  logic        key,
  input  logic        nx,
  input  acc_e        acc,
  input  logic        have_rec,
  input  logic [31:0] rec_w1,
  output logic        w0_match,
  output logic        consistent,
  output logic        granted,
  output logic [2:0]  rights
);
  always_comb begin
    w0_match   = w0[VALID_BIT] && (w0[HSEL_BIT] == pass) && ((w0 & TAG_MASK) == cmp);
    consistent = !have_rec || ((rec_w1 & CONS_MASK) == (w1 & CONS_MASK));
    rights     = pp_rights(key, w1[1:0], nx);
    granted    = access_ok(rights, acc);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int AW      = 32,
  parameter int HASH_W  = 19,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [HASH_W-1:0] req_hash,
  input  logic [31:0]       req_cmp,
  input  logic              req_key,
  input  logic              req_nx,
  input  logic [1:0]        req_acc,
  input  logic [AW-1:0]     cfg_base,
  input  logic [HASH_W-1:0] cfg_mask,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [31:0]       rsp_word,
  output logic [2:0]        rsp_prot
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_W0, ST_RD1, ST_W1, ST_END, ST_RSP
  } st_e;

  st_e               st;
  logic              pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic [31:0]       w0_q;
  logic [HASH_W-1:0] hash_q;
  logic [31:0]       cmp_q;
  logic              key_q, nx_q;
  acc_e              acc_q;
  logic              have_rec_q;
  logic [31:0]       rec_w1_q;
  logic [2:0]        rec_rights_q;
  logic              sel_q, sel_ok_q;
  logic [IDX_W-1:0]  sel_idx_q;
  logic [31:0]       sel_w1_q;
  res_e              pres_q, prim_q;
  res_e              code_q;
  logic [31:0]       word_q;
  logic [2:0]        prot_q;

  // Named internal events
  logic        w0_match, consistent, granted;
  logic [2:0]  rights;
  logic        ev_w0_in, ev_w1_in, ev_incon, ev_grant, ev_viol, ev_last;
  logic [31:0] new_w1;
  logic        wb_need;
  res_e        final_res;
  logic        word_sel;
  logic [IDX_W-1:0] addr_idx;

  hpt_pte_eval u_eval (
    .w0(ev_w0_in ? mem_rdata : w0_q), .w1(mem_rdata), .cmp(cmp_q),
    .pass(pass_q), .key(key_q), .nx(nx_q), .acc(acc_q),
    .have_rec(have_rec_q), .rec_w1(rec_w1_q),
    .w0_match(w0_match), .consistent(consistent), .granted(granted), .rights(rights)
  );

  assign word_sel = (st == ST_RD1) || (st == ST_END);
  assign addr_idx = (st == ST_END) ? sel_idx_q : idx_q;

  hpt_grp_addr #(.AW(AW), .HASH_W(HASH_W), .ENTRIES(ENTRIES)) u_addr (
    .base(cfg_base), .mask(cfg_mask), .hash(hash_q), .pass(pass_q),
    .idx(addr_idx), .word_sel(word_sel), .addr(mem_addr)
  );

  always_comb begin
    ev_w0_in  = (st == ST_W0) && mem_rvalid;
    ev_w1_in  = (st == ST_W1) && mem_rvalid;
    ev_incon  = ev_w1_in && !consistent;
    ev_grant  = ev_w1_in && consistent && granted;
    ev_viol   = ev_w1_in && consistent && !granted;
    ev_last   = (idx_q == LAST_IDX);
    new_w1    = merge_flags(sel_w1_q, sel_ok_q, acc_q == ACC_WRITE);
    wb_need   = sel_q && (new_w1 != sel_w1_q);
    final_res = (pres_q == RES_MISS) ? prim_q : pres_q;
  end

  assign req_ready = (st == ST_IDLE);
  assign mem_rd    = (st == ST_RD0) || (st == ST_RD1);
  assign mem_wr    = (st == ST_END) && wb_need;
  assign mem_wdata = new_w1;
  assign rsp_valid = (st == ST_RSP);
  assign rsp_code  = code_q;
  assign rsp_word  = word_q;
  assign rsp_prot  = prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      pass_q <= 1'b0; idx_q <= '0; w0_q <= '0; hash_q <= '0; cmp_q <= '0;
      key_q <= 1'b0; nx_q <= 1'b0; acc_q <= ACC_READ;
      have_rec_q <= 1'b0; rec_w1_q <= '0; rec_rights_q <= '0;
      sel_q <= 1'b0; sel_ok_q <= 1'b0; sel_idx_q <= '0; sel_w1_q <= '0;
      pres_q <= RES_MISS; prim_q <= RES_MISS;
      code_q <= RES_MISS; word_q <= '0; prot_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          hash_q <= req_hash; cmp_q <= req_cmp; key_q <= req_key; nx_q <= req_nx;
          acc_q <= acc_e'(req_acc);
          pass_q <= 1'b0; idx_q <= '0; have_rec_q <= 1'b0; sel_q <= 1'b0;
          pres_q <= RES_MISS; prim_q <= RES_MISS;
          st <= ST_RD0;
        end
        ST_RD0: st <= ST_W0;
        ST_W0: if (mem_rvalid) begin
          w0_q <= mem_rdata;
          if (w0_match)     st <= ST_RD1;
          else if (ev_last) st <= ST_END;
          else begin idx_q <= idx_q + 1'b1; st <= ST_RD0; end
        end
        ST_RD1: st <= ST_W1;
        ST_W1: if (mem_rvalid) begin
          if (!consistent) begin
            pres_q <= RES_INCON; sel_q <= 1'b0; st <= ST_END;
          end else begin
            have_rec_q <= 1'b1; rec_w1_q <= mem_rdata; rec_rights_q <= rights;
            sel_q <= 1'b1; sel_idx_q <= idx_q; sel_w1_q <= mem_rdata; sel_ok_q <= granted;
            if (granted) begin
              pres_q <= RES_HIT; st <= ST_END;
            end else begin
              pres_q <= RES_PROT;
              if (ev_last) st <= ST_END;
              else begin idx_q <= idx_q + 1'b1; st <= ST_RD0; end
            end
          end
        end
        ST_END: begin
          if (sel_q) rec_w1_q <= new_w1;
          if (!pass_q && pres_q != RES_HIT) begin
            prim_q <= pres_q; pass_q <= 1'b1; idx_q <= '0;
            sel_q <= 1'b0; pres_q <= RES_MISS; st <= ST_RD0;
          end else begin
            code_q <= final_res;
            if (final_res == RES_HIT || final_res == RES_PROT) begin
              word_q <= sel_q ? new_w1 : rec_w1_q;
              prot_q <= rec_rights_q;
            end else begin
              word_q <= '0; prot_q <= '0;
            end
            st <= ST_RSP;
          end
        end
        ST_RSP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R8
  AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[REF_BIT]); // R8
  AST_WB_WORD1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr[2:0] == 3'b100)); // R1
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_HIT_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RES_HIT) |-> access_ok(rsp_prot, acc_q)); // R4
  AST_PROT_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RES_PROT) |-> !access_ok(rsp_prot, acc_q)); // R5
  AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code[1]) |-> (rsp_word == 32'd0 && rsp_prot == 3'd0)); // R9
  AST_INCON_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_incon |=> !wb_need); // R7
endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
  localparam int AW = 32;
  localparam int HW = 19;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [HW-1:0] MASK = 19'h3F;
  localparam logic [31:0] CMP = 32'h0000_9185;
  localparam logic [31:0] W0P = 32'h8000_9185;
  localparam logic [31:0] W0S = 32'h8000_91C5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [HW-1:0] req_hash = '0;
  logic [31:0] req_cmp = '0;
  logic req_key = 1'b0, req_nx = 1'b0;
  logic [1:0] req_acc = 2'd0;
  logic mem_rd, mem_wr, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic [31:0] rsp_word;
  logic [2:0] rsp_prot;

  hpt_walker #(.AW(AW), .HASH_W(HW), .ENTRIES(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hash(req_hash), .req_cmp(req_cmp), .req_key(req_key), .req_nx(req_nx),
    .req_acc(req_acc), .cfg_base(BASE), .cfg_mask(MASK),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_word(rsp_word), .rsp_prot(rsp_prot)
  );

  logic [31:0] mem [1024];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_wa = '0, last_wd = '0;
  int checks = 0, errors = 0;
  logic [1:0] r_code;
  logic [31:0] r_word;
  logic [2:0] r_prot;
  int r_rd, r_wr;

  function automatic int widx(logic [31:0] a);
    return int'(((a - BASE) >> 2) & 32'h3FF);
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_rd;
    if (mem_rd) begin
      mem_rdata <= mem[widx(mem_addr)];
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr) begin
      wr_cnt <= wr_cnt + 1;
      last_wa <= mem_addr;
      last_wd <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
  endtask

  task automatic put(input int grp, input int idx, input logic [31:0] w0, input logic [31:0] w1);
    mem[grp * 16 + idx * 2]     = w0;
    mem[grp * 16 + idx * 2 + 1] = w1;
  endtask

  task automatic run(input logic [HW-1:0] h, input logic key, input logic nx, input logic [1:0] acc);
    int rd0, wr0;
    bit done;
    done = 0;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_hash = h; req_cmp = CMP; req_key = key; req_nx = nx; req_acc = acc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 400; n++) begin
      if (rsp_valid) begin done = 1; break; end
      @(negedge clk);
    end
    if (!done) chk(0, "R9 response timeout", 32'd0, 32'd1);
    r_code = rsp_code; r_word = rsp_word; r_prot = rsp_prot;
    r_rd = rd_cnt - rd0; r_wr = wr_cnt - wr0;
  endtask

  function automatic logic [2:0] exp_rights(logic key, logic [1:0] pp, logic nx);
    logic [1:0] wr;
    case ({key, pp})
      3'b000, 3'b001, 3'b010: wr = 2'b11;
      3'b011:                 wr = 2'b01;
      3'b100:                 wr = 2'b00;
      3'b110:                 wr = 2'b11;
      default:                wr = 2'b01;
    endcase
    return {wr[0] && !nx, wr[1], wr[0]};
  endfunction

  task automatic t_reset();
    chk(req_ready && !rsp_valid && !mem_rd && !mem_wr, "R9 reset state",
        {28'd0, req_ready, rsp_valid, mem_rd, mem_wr}, 32'h8);
  endtask

  task automatic t_empty();
    clear_mem();
    run(19'd5, 1'b0, 1'b0, 2'd0);
    chk(r_code == 2'd2, "R6 empty table miss", 32'(r_code), 32'd2);
    chk(r_rd == 16, "R2 only word0 reads on empty", 32'(r_rd), 32'd16);
    chk(r_wr == 0 && r_word == 0 && r_prot == 0, "R9 miss zero outputs", r_word, 32'd0);
  endtask

  task automatic t_primary_hit();
    clear_mem();
    put(5, 3, W0P, 32'h0002_3012);
    run(19'h7C5, 1'b0, 1'b0, 2'd0);
    chk(r_code == 2'd0, "R4 primary hit code", 32'(r_code), 32'd0);
    chk(r_word == 32'h0002_3112 && r_prot == 3'b111, "R4 hit word/prot", r_word, 32'h0002_3112);
    chk(r_rd == 5, "R4 scan stops at grant", 32'(r_rd), 32'd5);
    chk(r_wr == 1 && last_wa == 32'h0001_015C, "R1 write-back address", last_wa, 32'h0001_015C);
  endtask

  task automatic t_write_flags();
    clear_mem();
    put(5, 0, W0P, 32'h0003_4000);
    run(19'd5, 1'b0, 1'b0, 2'd1);
    chk(r_code == 2'd0 && r_word == 32'h0003_4180, "R8 granted write sets R and C", r_word, 32'h0003_4180);
    chk(r_wr == 1 && last_wd == 32'h0003_4180, "R8 write data", last_wd, 32'h0003_4180);
    put(5, 0, W0P, 32'h0003_4180);
    run(19'd5, 1'b0, 1'b0, 2'd1);
    chk(r_wr == 0 && r_word == 32'h0003_4180, "R8 no write when flags unchanged", 32'(r_wr), 32'd0);
  endtask

  task automatic t_candidates();
    clear_mem();
    put(5, 0, W0S, 32'h0000_1002);
    put(5, 1, 32'h0000_9185, 32'h0000_2002);
    put(5, 2, 32'h8000_9186, 32'h0000_3002);
    put(5, 4, W0P, 32'h0000_7002);
    run(19'd5, 1'b0, 1'b0, 2'd0);
    chk(r_code == 2'd0 && r_word == 32'h0000_7102, "R2 skips non-candidates", r_word, 32'h0000_7102);
    chk(r_rd == 6 && last_wa == 32'h0001_0164, "R2 word1 read only on match", 32'(r_rd), 32'd6);
  endtask

  task automatic t_violation();
    clear_mem();
    put(5, 1, W0P, 32'h0000_8000);
    run(19'd5, 1'b1, 1'b0, 2'd0);
    chk(r_code == 2'd1 && r_word == 32'h0000_8100 && r_prot == 3'b000, "R5 violation kept over secondary miss", r_word, 32'h0000_8100);
    chk(r_rd == 17, "R6 secondary pass read count", 32'(r_rd), 32'd17);
    chk(r_wr == 1 && last_wa == 32'h0001_014C && last_wd == 32'h0000_8100, "R8 ref-only write on violation", last_wd, 32'h0000_8100);
  endtask

  task automatic t_last_violation();
    clear_mem();
    put(5, 1, W0P, 32'h0000_8000);
    put(5, 5, W0P, 32'h0000_8000);
    run(19'd5, 1'b1, 1'b0, 2'd0);
    chk(r_code == 2'd1, "R5 two violations code", 32'(r_code), 32'd1);
    chk(r_wr == 1 && last_wa == 32'h0001_016C, "R5 last violating entry selected", last_wa, 32'h0001_016C);
  endtask

  task automatic t_incon();
    clear_mem();
    put(5, 1, W0P, 32'h0000_9000);
    put(5, 2, W0P, 32'h0000_A000);
    put(5, 6, W0P, 32'h0000_9000);
    run(19'd5, 1'b1, 1'b0, 2'd0);
    chk(r_code == 2'd3 && r_word == 0, "R7 inconsistency result", 32'(r_code), 32'd3);
    chk(r_wr == 0, "R7 no write-back on inconsistency", 32'(r_wr), 32'd0);
    chk(r_rd == 13, "R7 scan ends at inconsistency", 32'(r_rd), 32'd13);
  endtask

  task automatic t_secondary();
    clear_mem();
    put(5, 0, W0S, 32'h0000_1003);
    put(58, 0, W0S, 32'h0000_B003);
    run(19'd5, 1'b0, 1'b0, 2'd2);
    chk(r_code == 2'd0 && r_word == 32'h0000_B103 && r_prot == 3'b101, "R6 secondary hit with complemented hash", r_word, 32'h0000_B103);
    chk(r_wr == 1 && last_wa == 32'h0001_0E84, "R6 secondary write address", last_wa, 32'h0001_0E84);
  endtask

  task automatic t_nx();
    clear_mem();
    put(5, 0, W0P, 32'h0000_C002);
    run(19'd5, 1'b0, 1'b1, 2'd2);
    chk(r_code == 2'd1 && r_prot == 3'b011 && r_word == 32'h0000_C102, "R3 fetch denied by no-execute", {29'd0, r_prot}, 32'd3);
  endtask

  task automatic t_cross_pass();
    clear_mem();
    put(5, 0, W0P, 32'h0000_D000);
    put(58, 0, W0S, 32'h0000_E000);
    run(19'd5, 1'b1, 1'b0, 2'd0);
    chk(r_code == 2'd3, "R6 R7 secondary inconsistency replaces violation", 32'(r_code), 32'd3);
    chk(r_wr == 1 && last_wa == 32'h0001_0144, "R8 primary write before secondary", last_wa, 32'h0001_0144);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 4; p++) begin
        for (int a = 0; a < 3; a++) begin
          logic [2:0] rt;
          logic ok;
          logic [31:0] w1, ew;
          clear_mem();
          w1 = 32'h0000_5000 | 32'(p);
          put(5, 0, W0P, w1);
          rt = exp_rights(k[0], p[1:0], 1'b0);
          ok = (a == 0) ? rt[0] : (a == 1) ? rt[1] : rt[2];
          ew = w1 | 32'h100 | ((ok && a == 1) ? 32'h80 : 32'h0);
          run(19'd5, k[0], 1'b0, a[1:0]);
          chk(r_code == (ok ? 2'd0 : 2'd1) && r_word == ew && r_prot == rt,
              "R3 protection table", {r_code, 27'd0, r_prot}, {(ok ? 2'd0 : 2'd1), 27'd0, rt});
        end
      end
    end
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_empty();
    t_primary_hit();
    t_write_flags();
    t_candidates();
    t_violation();
    t_last_violation();
    t_incon();
    t_secondary();
    t_nx();
    t_cross_pass();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule